// File: doc/BRIEF.md
# Dual Match Timer with Snapshot Wide Counter

This block is a register-mapped timer that gives each of two processors its own one-shot event source. It also provides one shared wide time base. Each event channel has a 32-bit up-counter, a compare value and a prescaler. When the counter reaches the compare value on a prescaled step, the channel raises a sticky status flag. The flag drives that channel's interrupt line when the interrupt gate is open. Software arms an event in three steps: clear the counter, write the delay into the compare register, then set the channel's enable bits.

The wide counter is 64 bits and has its own prescaler. Because software reads it in two 32-bit halves, a read goes through a command: a write to the wide control register copies the running value into a snapshot pair, and software then reads the two halves of that pair at leisure. The same control register carries a load command, which copies a software-written 64-bit value into the counter and starts it. The wide counter stays idle from reset until the first load.

Top module: `dual_match_timer`

## Requirements
- R1: After reset every readable register returns 0, both interrupt lines are low and no counter advances.
- R2: A running counter advances once every N+1 clocks, where N is bits [31:16] of that counter's control register.
- R3: In a channel control register, bit 0 runs the counter, bit 1 enables compare detection and bit 2 opens the interrupt gate. The register reads back bits [31:16] and [2:0] as written, and every other bit reads 0.
- R4: When a channel starts from a count of 0 with compare value D and detection on, its status bit and interrupt rise exactly D*(N+1) clock edges after the write that enables it, and not before.
- R5: A write to a channel count register replaces the count directly. After a match the count keeps advancing, and it wraps from 0xFFFFFFFF to 0, so a compare value of 0 is hit on that wrap.
- R6: The status register at 0x60 holds bit i for channel i. Writing 1 to a bit clears it, 0 bits leave it unchanged, and 0xFFFF clears all bits. Interrupt i equals status bit i AND control bit 2 of channel i.
- R7: Clearing a channel's run bit freezes its count.
- R8: Writing the wide control register (0x68) with bit 0 = 1 and bit 1 = 0 copies the current wide count into the snapshot words, low half at 0x7C and high half at 0x80. The snapshot then holds until the next such command, and a load command does not change it.
- R9: Writing 0x68 with bits 0 and 1 both set loads the wide counter from the load words (low at 0x74, high at 0x78), restarts its prescaler phase and starts it counting. Bit 1 alone does nothing.
- R10: Bits 0 and 1 of 0x68 read back 0 and its bits [31:16] read back as written. The live wide count reads at 0x6C (low) and 0x70 (high), carries from low to high, and wraps modulo 2^64.
- R11: Channel i has its control register at 0x00+4i, its compare register at 0x18+4i and its count register at 0x48+4i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for counters and registers |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | NCH | One interrupt per event channel |

## Verification
A register write takes effect on the clock edge that samples the strobe, and read data follows the address with no clock delay. The bench therefore drives every stimulus on a falling edge and checks one falling edge after the edge that carries the write.

A channel's interrupt is due D*(N+1) edges after the enabling write. The bench waits one edge short of that point and checks that the line is still low, then waits one more edge and checks that it is high.

The wide counter shows a loaded value on the first falling edge after the load, steps by one per edge when its prescaler is zero, and steps every third edge when the field is 2. A snapshot captures the value held just before the command's edge, and the expected values are counted on that basis.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
   localparam int unsigned REG_W       = 32;
   localparam int unsigned DIV_LSB     = 16;
   localparam int unsigned A_CTRL      = 32'h00;
   localparam int unsigned A_MATCH     = 32'h18;
   localparam int unsigned A_COUNT     = 32'h48;
   localparam int unsigned A_STAT      = 32'h60;
   localparam int unsigned A_WCTRL     = 32'h68;
   localparam int unsigned A_WLIVE_LO  = 32'h6C;
   localparam int unsigned A_WLIVE_HI  = 32'h70;
   localparam int unsigned A_WLOAD_LO  = 32'h74;
   localparam int unsigned A_WLOAD_HI  = 32'h78;
   localparam int unsigned A_WSNAP_LO  = 32'h7C;
   localparam int unsigned A_WSNAP_HI  = 32'h80;
   localparam int unsigned MAX_CHAN    = 6;

   typedef struct packed {
      logic gate;
      logic detect;
      logic run;
   } chan_en_t;

   typedef enum logic [1:0] {
      WCMD_NONE,
      WCMD_SNAP,
      WCMD_LOAD
   } wide_cmd_e;
endpackage

// File: rtl/mtmr_prescaler.sv
module mtmr_prescaler #(
   parameter int unsigned PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          restart,
   input  logic [PW-1:0] div,
   output logic          tick
);
   logic [PW-1:0] phase_q;

   if (PW < 1) begin : g_bad_pw
      $error("mtmr_prescaler: PW must be at least 1");
   end

   assign tick = en && !restart && (phase_q >= div);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (!en || restart || tick) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

   assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/mtmr_channel.sv
module mtmr_channel
   import mtmr_pkg::*;
#(
   parameter int unsigned CW = 32,
   parameter int unsigned PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctrl_we,
   input  logic [PW-1:0] ctrl_div,
   input  logic [2:0]    ctrl_en,
   input  logic          match_we,
   input  logic          cnt_we,
   input  logic [CW-1:0] wval,
   input  logic          stat_clr,
   output logic [31:0]   ctrl_rd,
   output logic [CW-1:0] match_q,
   output logic [CW-1:0] cnt_q,
   output logic          status,
   output logic          irq
);
   localparam int unsigned DIV_POS = DIV_LSB;

   chan_en_t      en_q;
   logic [PW-1:0] div_q;
   logic          tick;
   logic [CW-1:0] cnt_nxt;
   logic          hit;

   if (CW < 2 || CW > 32) begin : g_bad_cw
      $error("mtmr_channel: CW must lie in 2..32");
   end
   if (PW > 16) begin : g_bad_pw
      $error("mtmr_channel: PW must not exceed 16");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= '0;
         div_q <= '0;
      end else if (ctrl_we) begin
         en_q  <= chan_en_t'(ctrl_en);
         div_q <= ctrl_div;
      end
   end

   assign ctrl_rd = (32'(div_q) << DIV_POS) | {29'b0, en_q};

   mtmr_prescaler #(.PW(PW)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_q.run),
      .restart (cnt_we),
      .div     (div_q),
      .tick    (tick)
   );

   assign cnt_nxt = cnt_q + 1'b1;
   assign hit     = tick && en_q.detect && (cnt_nxt == match_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_q <= '0;
      end else if (match_we) begin
         match_q <= wval;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_we) begin
         cnt_q <= wval;
      end else if (tick) begin
         cnt_q <= cnt_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= 1'b0;
      end else if (hit) begin
         status <= 1'b1;
      end else if (stat_clr) begin
         status <= 1'b0;
      end
   end

   assign irq = status & en_q.gate;

   assert_stop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q.run && !cnt_we) |=> $stable(cnt_q));
   assert_hit_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(status) && $stable(match_q)) |-> (cnt_q == match_q));
   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !hit) |=> !status);
endmodule

// File: rtl/mtmr_wide.sv
module mtmr_wide
   import mtmr_pkg::*;
#(
   parameter int unsigned WW = 64,
   parameter int unsigned PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  wide_cmd_e     cmd,
   input  logic [PW-1:0] div,
   input  logic [WW-1:0] load_val,
   output logic [WW-1:0] live,
   output logic [WW-1:0] snap
);
   logic run_q;
   logic tick;
   logic is_load;

   if (WW != 64) begin : g_bad_ww
      $error("mtmr_wide: WW must be 64 for the two-word map");
   end

   assign is_load = (cmd == WCMD_LOAD);

   mtmr_prescaler #(.PW(PW)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (run_q),
      .restart (is_load),
      .div     (div),
      .tick    (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live  <= '0;
         run_q <= 1'b0;
      end else if (is_load) begin
         live  <= load_val;
         run_q <= 1'b1;
      end else if (tick) begin
         live  <= live + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap <= '0;
      end else if (cmd == WCMD_SNAP) begin
         snap <= live;
      end
   end

   assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != WCMD_SNAP) |=> $stable(snap));
   assert_snap_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == WCMD_SNAP) |=> (snap == $past(live)));
   assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      is_load |=> (live == $past(load_val)));
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
   import mtmr_pkg::*;
#(
   parameter int unsigned NCH    = 2,
   parameter int unsigned CW     = 32,
   parameter int unsigned PW     = 16,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [NCH-1:0]    irq
);
   localparam int unsigned WW = 2 * REG_W;

   logic [31:0]    addr32;
   logic [PW-1:0]  wdiv_q;
   logic [31:0]    wload_lo_q;
   logic [31:0]    wload_hi_q;
   wide_cmd_e      wcmd;
   logic [WW-1:0]  wlive;
   logic [WW-1:0]  wsnap;
   logic           wctrl_hit;

   logic [31:0]    ch_ctrl  [NCH];
   logic [CW-1:0]  ch_match [NCH];
   logic [CW-1:0]  ch_cnt   [NCH];
   logic [NCH-1:0] ch_stat;

   if (NCH < 1 || NCH > MAX_CHAN) begin : g_bad_nch
      $error("dual_match_timer: NCH must lie in 1..6");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
      $error("dual_match_timer: ADDR_W must lie in 8..32");
   end
   if (PW < 1 || PW > 16) begin : g_bad_pw
      $error("dual_match_timer: PW must lie in 1..16");
   end

   assign addr32    = 32'(reg_addr);
   assign wctrl_hit = reg_wr && (addr32 == A_WCTRL);

   always_comb begin
      wcmd = WCMD_NONE;
      if (wctrl_hit && reg_wdata[0]) begin
         wcmd = reg_wdata[1] ? WCMD_LOAD : WCMD_SNAP;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wdiv_q     <= '0;
         wload_lo_q <= '0;
         wload_hi_q <= '0;
      end else if (reg_wr) begin
         if (addr32 == A_WCTRL)   wdiv_q     <= reg_wdata[DIV_LSB +: PW];
         if (addr32 == A_WLOAD_LO) wload_lo_q <= reg_wdata;
         if (addr32 == A_WLOAD_HI) wload_hi_q <= reg_wdata;
      end
   end

   for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
      logic ctrl_we, match_we, cnt_we, stat_clr;
      assign ctrl_we  = reg_wr && (addr32 == A_CTRL  + 4 * gi);
      assign match_we = reg_wr && (addr32 == A_MATCH + 4 * gi);
      assign cnt_we   = reg_wr && (addr32 == A_COUNT + 4 * gi);
      assign stat_clr = reg_wr && (addr32 == A_STAT) && reg_wdata[gi];

      mtmr_channel #(.CW(CW), .PW(PW)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .ctrl_we  (ctrl_we),
         .ctrl_div (reg_wdata[DIV_LSB +: PW]),
         .ctrl_en  (reg_wdata[2:0]),
         .match_we (match_we),
         .cnt_we   (cnt_we),
         .wval     (reg_wdata[CW-1:0]),
         .stat_clr (stat_clr),
         .ctrl_rd  (ch_ctrl[gi]),
         .match_q  (ch_match[gi]),
         .cnt_q    (ch_cnt[gi]),
         .status   (ch_stat[gi]),
         .irq      (irq[gi])
      );
   end

   mtmr_wide #(.WW(WW), .PW(PW)) u_wide (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (wcmd),
      .div      (wdiv_q),
      .load_val ({wload_hi_q, wload_lo_q}),
      .live     (wlive),
      .snap     (wsnap)
   );

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NCH; i++) begin
         if (addr32 == A_CTRL  + 4 * i) reg_rdata = ch_ctrl[i];
         if (addr32 == A_MATCH + 4 * i) reg_rdata = 32'(ch_match[i]);
         if (addr32 == A_COUNT + 4 * i) reg_rdata = 32'(ch_cnt[i]);
      end
      case (addr32)
         A_STAT:     reg_rdata = 32'(ch_stat);
         A_WCTRL:    reg_rdata = 32'(wdiv_q) << DIV_LSB;
         A_WLIVE_LO: reg_rdata = wlive[31:0];
         A_WLIVE_HI: reg_rdata = wlive[63:32];
         A_WLOAD_LO: reg_rdata = wload_lo_q;
         A_WLOAD_HI: reg_rdata = wload_hi_q;
         A_WSNAP_LO: reg_rdata = wsnap[31:0];
         A_WSNAP_HI: reg_rdata = wsnap[63:32];
         default:    ;
      endcase
   end
endmodule

// File: tb/dual_match_timer_tb.sv
module dual_match_timer_tb;
   import mtmr_pkg::*;

   typedef struct packed {
      logic [15:0] div;
      logic [15:0] dly;
   } vec_t;

   localparam int NVEC = 5;
   localparam vec_t VEC [NVEC] = '{
      '{16'd0, 16'd1},
      '{16'd0, 16'd5},
      '{16'd3, 16'd4},
      '{16'd1, 16'd7},
      '{16'd2, 16'd3}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic [1:0]  irq;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   dual_match_timer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] r, r2;
      rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1: everything zero and idle after reset
      for (int a = 0; a <= 8'h80; a += 4) begin
         rd_reg(8'(a), r);
         chk("R1 reset register", {32'(a), r}, {32'(a), 32'h0});
      end
      chk("R1 irq after reset", 64'(irq), 64'h0);

      // R2 R4 R11: table of prescaler and delay, alternate channels
      for (int k = 0; k < NVEC; k++) begin
         int ch;
         int due;
         logic [7:0] o;
         ch  = k % 2;
         o   = 8'(4 * ch);
         due = int'(VEC[k].dly) * (int'(VEC[k].div) + 1);
         wr_reg(8'(A_CTRL) + o, 32'h0);
         wr_reg(8'(A_COUNT) + o, 32'h0);
         wr_reg(8'(A_MATCH) + o, 32'(VEC[k].dly));
         wr_reg(8'(A_STAT), 32'h3);
         wr_reg(8'(A_CTRL) + o, {VEC[k].div, 16'h0007});
         if (due > 1) begin
            repeat (due - 1) @(negedge clk);
            chk("R4 irq not yet due", 64'(irq[ch]), 64'h0);
         end
         @(negedge clk);
         chk("R4 irq at due edge", 64'(irq[ch]), 64'h1);
         rd_reg(8'(A_STAT), r);
         chk("R6 status bit set", 64'(r[ch]), 64'h1);
         rd_reg(8'(A_COUNT) + o, r);
         chk("R11 count register equals match", 64'(r), 64'(VEC[k].dly));
         repeat (int'(VEC[k].div) + 1) @(negedge clk);
         rd_reg(8'(A_COUNT) + o, r);
         chk("R2 R5 count steps past match", 64'(r), 64'(VEC[k].dly) + 1);
      end
      wr_reg(8'(A_CTRL), 32'h0);
      wr_reg(8'(A_CTRL) + 8'h4, 32'h0);
      wr_reg(8'(A_STAT), 32'hFFFF);

      // R3: control readback mask
      wr_reg(8'(A_CTRL) + 8'h4, 32'hABCD_FFF8);
      rd_reg(8'(A_CTRL) + 8'h4, r);
      chk("R3 ctrl readback masks middle bits", 64'(r), 64'hABCD_0000);
      wr_reg(8'(A_CTRL) + 8'h4, 32'h1234_0006);
      rd_reg(8'(A_CTRL) + 8'h4, r);
      chk("R3 ctrl readback enable bits", 64'(r), 64'h1234_0006);

      // R6: interrupt gate and selective clear on channel 1
      wr_reg(8'(A_CTRL) + 8'h4, 32'h0);
      wr_reg(8'(A_COUNT) + 8'h4, 32'h0);
      wr_reg(8'(A_MATCH) + 8'h4, 32'h2);
      wr_reg(8'(A_CTRL) + 8'h4, 32'h0000_0003);
      repeat (2) @(negedge clk);
      rd_reg(8'(A_STAT), r);
      chk("R6 status set with gate closed", 64'(r), 64'h2);
      chk("R6 irq held low by gate", 64'(irq[1]), 64'h0);
      wr_reg(8'(A_CTRL) + 8'h4, 32'h0000_0007);
      chk("R6 irq follows gate", 64'(irq[1]), 64'h1);
      wr_reg(8'(A_STAT), 32'h1);
      rd_reg(8'(A_STAT), r);
      chk("R6 zero bit leaves status", 64'(r), 64'h2);
      wr_reg(8'(A_STAT), 32'h2);
      rd_reg(8'(A_STAT), r);
      chk("R6 one bit clears status", 64'(r), 64'h0);
      chk("R6 irq drops on clear", 64'(irq[1]), 64'h0);

      // R7: stopped counter holds
      wr_reg(8'(A_CTRL) + 8'h4, 32'h0);
      rd_reg(8'(A_COUNT) + 8'h4, r);
      repeat (5) @(negedge clk);
      rd_reg(8'(A_COUNT) + 8'h4, r2);
      chk("R7 stopped count frozen", 64'(r2), 64'(r));

      // R5: direct write and 32-bit wrap hitting compare 0
      wr_reg(8'(A_COUNT), 32'hFFFF_FFFF);
      wr_reg(8'(A_MATCH), 32'h0);
      wr_reg(8'(A_CTRL), 32'h0000_0007);
      rd_reg(8'(A_COUNT), r);
      chk("R5 direct count write", 64'(r), 64'hFFFF_FFFF);
      @(negedge clk);
      rd_reg(8'(A_COUNT), r);
      chk("R5 count wraps to zero", 64'(r), 64'h0);
      chk("R5 wrap hits compare zero", 64'(irq[0]), 64'h1);
      wr_reg(8'(A_CTRL), 32'h0);
      wr_reg(8'(A_STAT), 32'hFFFF);
      rd_reg(8'(A_STAT), r);
      chk("R6 0xFFFF clears all", 64'(r), 64'h0);

      // R9: bit 1 alone leaves the wide counter idle
      wr_reg(8'(A_WCTRL), 32'h2);
      repeat (3) @(negedge clk);
      rd_reg(8'(A_WLIVE_LO), r);
      chk("R9 bit1 alone does not start", 64'(r), 64'h0);

      // R9 R8: load, step, snapshot
      wr_reg(8'(A_WLOAD_LO), 32'h89AB_CDEF);
      wr_reg(8'(A_WLOAD_HI), 32'h0123_4567);
      wr_reg(8'(A_WCTRL), 32'h3);
      rd_reg(8'(A_WLIVE_LO), r); rd_reg(8'(A_WLIVE_HI), r2);
      chk("R9 load value visible", {r2, r}, 64'h0123_4567_89AB_CDEF);
      @(negedge clk);
      rd_reg(8'(A_WLIVE_LO), r);
      chk("R9 counts after load", 64'(r), 64'h89AB_CDF0);
      wr_reg(8'(A_WCTRL), 32'h1);
      rd_reg(8'(A_WSNAP_LO), r); rd_reg(8'(A_WSNAP_HI), r2);
      chk("R8 snapshot value", {r2, r}, 64'h0123_4567_89AB_CDF1);
      rd_reg(8'(A_WLIVE_LO), r);
      chk("R10 live count low", 64'(r), 64'h89AB_CDF2);
      repeat (4) @(negedge clk);
      rd_reg(8'(A_WSNAP_LO), r);
      chk("R8 snapshot holds", 64'(r), 64'h89AB_CDF1);
      rd_reg(8'(A_WCTRL), r);
      chk("R10 command bits read zero", 64'(r), 64'h0);

      // R9 R10: prescaled wide counter and low-to-high carry
      wr_reg(8'(A_WLOAD_LO), 32'hFFFF_FFFF);
      wr_reg(8'(A_WLOAD_HI), 32'h0);
      wr_reg(8'(A_WCTRL), 32'h0002_0003);
      repeat (2) @(negedge clk);
      rd_reg(8'(A_WLIVE_LO), r); rd_reg(8'(A_WLIVE_HI), r2);
      chk("R9 wide prescaler holds", {r2, r}, 64'h0000_0000_FFFF_FFFF);
      @(negedge clk);
      rd_reg(8'(A_WLIVE_LO), r); rd_reg(8'(A_WLIVE_HI), r2);
      chk("R10 carry into high word", {r2, r}, 64'h0000_0001_0000_0000);
      rd_reg(8'(A_WCTRL), r);
      chk("R10 prescaler field readback", 64'(r), 64'h0002_0000);
      rd_reg(8'(A_WSNAP_LO), r);
      chk("R8 load leaves snapshot", 64'(r), 64'h89AB_CDF1);

      // R10: 64-bit wrap
      wr_reg(8'(A_WLOAD_HI), 32'hFFFF_FFFF);
      wr_reg(8'(A_WCTRL), 32'h3);
      @(negedge clk);
      rd_reg(8'(A_WLIVE_LO), r); rd_reg(8'(A_WLIVE_HI), r2);
      chk("R10 wide wrap to zero", {r2, r}, 64'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule